// File: doc/BRIEF.md
# Prefix-Select Binary Adder

This block adds two unsigned operands and a carry-in without a clock. The operand width is split into select groups of a fixed width. When the width does not divide evenly, the top group is narrower. Each group computes its own sum once, assuming no carry arrives. For that it uses a parallel-prefix (Ladner-Fischer style) generate/propagate tree of logarithmic depth. An increment-by-one stage then turns this result into the version that assumes a carry of one. The carry arriving from the group below drives a two-way selection that picks both the group sum and the group carry-out.

The lowest group has no selection stage. The external carry-in enters its prefix tree directly, as a seed of the first generate term. The carries between groups then pass through one multiplexer per group. The block is meant for datapaths where two ripple adders per group would cost too much area, but where a single full-width ripple chain would be too slow.

Top module: `csla_lf_bec`

## Requirements
- R1: `{cout_o, sum_o}` equals the unsigned sum `a_i + b_i + cin_i` for every input combination.
- R2: The carry that steers the select stage of each group equals the carry produced by all operand bits below that group's lowest bit, together with `cin_i`.
- R3: A carry created in the lowest bit ripples through several whole groups: 0x0FFF + 0x0000 + 1 gives sum 0x1000 and carry-out 0.
- R4: `cin_i` enters the lowest group directly: 0 + 0 + 1 gives sum 1 and carry-out 0. With all inputs zero the sum is 0.
- R5: When both operands are all ones, the sum is all ones except bit 0, which equals `cin_i`, and the carry-out is 1.
- R6: An all-ones operand plus zero plus a carry-in of 1 gives sum 0 and carry-out 1.
- R7: A group whose no-carry sum is all ones outputs zero and passes a carry of one upward when a carry enters it. Example: 0x00F8 + 0x0008 + 0 gives 0x0100.
- R8: When `DATA_W` is not a multiple of `GRP_W`, the narrower top group still yields a correct result (5-bit width, 2-bit groups).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | DATA_W | First operand, unsigned |
| b_i | input | DATA_W | Second operand, unsigned |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | DATA_W | Sum bits |
| cout_o | output | 1 | Carry out of the top bit |

## Verification
Every operand pair and carry-in is applied exhaustively to a 6-bit instance with 2-bit groups. This separates faults in the prefix tree, the increment stage and the select multiplexers, since each of them fails on some pattern. A 5-bit instance with 2-bit groups is also run exhaustively, which brings out errors that appear only in the narrower top group or in a single-bit prefix tree. Directed patterns on the 16-bit default cover the extremes:
- all-ones operands with each carry-in;
- an all-ones operand plus a carry-in;
- carries launched from bit 0 that travel across several groups;
- a group that wraps through its increment path.

Random operands at 16 bits then check the same paths at full width.

// File: rtl/csla_pkg.sv
package csla_pkg;
  function automatic int lf_levels(input int w);
    return (w <= 1) ? 0 : $clog2(w);
  endfunction

  function automatic int group_count(input int n, input int g);
    return (n + g - 1) / g;
  endfunction
endpackage

// File: rtl/lf_prefix_adder.sv
module lf_prefix_adder #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  localparam int LVL = csla_pkg::lf_levels(W);

  logic [W-1:0] gen0, prop0;
  logic [W-1:0] g_v, p_v, g_n, p_n;
  logic [W:0]   carry;

  assign gen0  = a_i & b_i;
  assign prop0 = a_i ^ b_i;

  // cin folded into bit 0 generate so all carries come from the tree
  always_comb begin
    g_v = gen0 | W'(prop0[0] & cin_i);
    p_v = prop0;
    g_n = g_v;
    p_n = p_v;
    for (int l = 0; l < LVL; l++) begin
      g_n = g_v;
      p_n = p_v;
      for (int i = 0; i < W; i++) begin
        if (((i >> l) & 1) == 1) begin
          g_n[i] = g_v[i] | (p_v[i] & g_v[((i >> l) << l) - 1]);
          p_n[i] = p_v[i] & p_v[((i >> l) << l) - 1];
        end
      end
      g_v = g_n;
      p_v = p_n;
    end
    carry[0] = cin_i;
    for (int i = 0; i < W; i++) carry[i+1] = g_v[i];
  end

  assign sum_o  = prop0 ^ carry[W-1:0];
  assign cout_o = carry[W];
endmodule

// File: rtl/excess1_conv.sv
module excess1_conv #(
  parameter int W = 4
) (
  input  logic [W-1:0] s_i,
  input  logic         co_i,
  output logic [W-1:0] s_o,
  output logic         co_o
);
  logic run;

  always_comb begin
    run = 1'b1;
    for (int i = 0; i < W; i++) begin
      s_o[i] = s_i[i] ^ run;
      run    = run & s_i[i];
    end
    co_o = co_i | run;
  end
endmodule

// File: rtl/csel_group.sv
module csel_group #(
  parameter int W     = 4,
  parameter bit FIRST = 1'b0
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  if (FIRST) begin : g_direct
    lf_prefix_adder #(.W(W)) u_lf (
      .a_i(a_i), .b_i(b_i), .cin_i(cin_i), .sum_o(sum_o), .cout_o(cout_o)
    );
  end else begin : g_select
    logic [W-1:0] s0, s1;
    logic         c0, c1;

    lf_prefix_adder #(.W(W)) u_lf (
      .a_i(a_i), .b_i(b_i), .cin_i(1'b0), .sum_o(s0), .cout_o(c0)
    );
    excess1_conv #(.W(W)) u_inc (
      .s_i(s0), .co_i(c0), .s_o(s1), .co_o(c1)
    );

    assign sum_o  = cin_i ? s1 : s0;
    assign cout_o = cin_i ? c1 : c0;
  end
endmodule

// File: rtl/csla_lf_bec.sv
module csla_lf_bec #(
  parameter int DATA_W = 16,
  parameter int GRP_W  = 4
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              cout_o
);
  localparam int NUM_GRP = csla_pkg::group_count(DATA_W, GRP_W);

  logic [NUM_GRP:0] grp_c;

  assign grp_c[0] = cin_i;

  for (genvar k = 0; k < NUM_GRP; k++) begin : g_grp
    localparam int LO = k * GRP_W;
    localparam int GW = (DATA_W - LO < GRP_W) ? (DATA_W - LO) : GRP_W;

    csel_group #(.W(GW), .FIRST(k == 0)) u_grp (
      .a_i   (a_i[LO +: GW]),
      .b_i   (b_i[LO +: GW]),
      .cin_i (grp_c[k]),
      .sum_o (sum_o[LO +: GW]),
      .cout_o(grp_c[k+1])
    );
  end

  assign cout_o = grp_c[NUM_GRP];
endmodule

// File: rtl/csla_lf_bec_chk.sv
module csla_lf_bec_chk #(
  parameter int DATA_W = 16,
  parameter int GRP_W  = 4
) (
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic              cin_i,
  input logic [DATA_W-1:0] sum_o,
  input logic              cout_o,
  input logic [csla_pkg::group_count(DATA_W, GRP_W):0] grp_c_i
);
  localparam int NUM_GRP = csla_pkg::group_count(DATA_W, GRP_W);

  logic [DATA_W:0] full, rc;

  always_comb begin
    full = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, cin_i};
    rc   = full ^ {1'b0, a_i} ^ {1'b0, b_i};

    a_r1_total_sum: assert ({cout_o, sum_o} == full)
      else $error("R1 total mismatch");

    for (int k = 0; k <= NUM_GRP; k++) begin
      a_r2_group_carry: assert (grp_c_i[k] == rc[(k * GRP_W > DATA_W) ? DATA_W : k * GRP_W])
        else $error("R2 group carry mismatch");
    end

    if (a_i == '0 && b_i == '0) begin
      a_r4_cin_direct: assert (sum_o == DATA_W'(cin_i) && !cout_o)
        else $error("R4 carry-in path");
    end

    if (a_i == '1 && b_i == '1) begin
      a_r5_all_ones: assert (cout_o && sum_o[DATA_W-1:1] == '1 && sum_o[0] == cin_i)
        else $error("R5 all-ones operands");
    end

    if (a_i == '1 && b_i == '0 && cin_i) begin
      a_r6_wrap: assert (sum_o == '0 && cout_o)
        else $error("R6 wrap to zero");
    end
  end
endmodule

bind csla_lf_bec csla_lf_bec_chk #(.DATA_W(DATA_W), .GRP_W(GRP_W)) u_chk (
  .a_i(a_i), .b_i(b_i), .cin_i(cin_i), .sum_o(sum_o), .cout_o(cout_o), .grp_c_i(grp_c)
);

// File: tb/csla_lf_bec_test.sv
`timescale 1ns/1ps
module csla_lf_bec_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic [15:0] a16, b16, s16;
  logic        c16, co16;
  logic [5:0]  a6, b6, s6;
  logic        c6, co6;
  logic [4:0]  a5, b5, s5;
  logic        c5, co5;

  csla_lf_bec #(.DATA_W(16), .GRP_W(4)) uut (
    .a_i(a16), .b_i(b16), .cin_i(c16), .sum_o(s16), .cout_o(co16));
  csla_lf_bec #(.DATA_W(6), .GRP_W(2)) uut_w6 (
    .a_i(a6), .b_i(b6), .cin_i(c6), .sum_o(s6), .cout_o(co6));
  csla_lf_bec #(.DATA_W(5), .GRP_W(2)) uut_w5 (
    .a_i(a5), .b_i(b5), .cin_i(c5), .sum_o(s5), .cout_o(co5));

  typedef struct {
    logic [16:0] e16;
    logic [6:0]  e6;
    logic [5:0]  e5;
    string       tag;
  } item_t;

  item_t sb_q[$];
  item_t mon_it;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic compare(input logic [31:0] got, input logic [31:0] exp,
                         input string tag, input string inst);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, inst, got, exp);
    end
  endtask

  task automatic drive(input logic [15:0] a, input logic [15:0] b, input logic c,
                       input logic [5:0] x6, input logic [5:0] y6, input logic z6,
                       input logic [4:0] x5, input logic [4:0] y5, input logic z5,
                       input string tag);
    item_t it;
    @(posedge clk);
    #1;
    a16 = a; b16 = b; c16 = c;
    a6 = x6; b6 = y6; c6 = z6;
    a5 = x5; b5 = y5; c5 = z5;
    it.e16 = {1'b0, a} + {1'b0, b} + {16'd0, c};
    it.e6  = {1'b0, x6} + {1'b0, y6} + {6'd0, z6};
    it.e5  = {1'b0, x5} + {1'b0, y5} + {5'd0, z5};
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic drive16(input logic [15:0] a, input logic [15:0] b, input logic c,
                         input string tag);
    drive(a, b, c, 6'd0, 6'd0, 1'b0, 5'd0, 5'd0, 1'b0, tag);
  endtask

  always @(negedge clk) begin
    if (rst_ni && sb_q.size() > 0) begin
      mon_it = sb_q.pop_front();
      compare({15'd0, co16, s16}, {15'd0, mon_it.e16}, mon_it.tag, "w16");
      compare({25'd0, co6, s6}, {25'd0, mon_it.e6}, mon_it.tag, "w6");
      compare({26'd0, co5, s5}, {26'd0, mon_it.e5}, {mon_it.tag, " R8"}, "w5");
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R1: got hang expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    a16 = '0; b16 = '0; c16 = 1'b0;
    a6 = '0; b6 = '0; c6 = 1'b0;
    a5 = '0; b5 = '0; c5 = 1'b0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;

    drive16(16'h0000, 16'h0000, 1'b0, "R4 zero");
    drive16(16'h0000, 16'h0000, 1'b1, "R4 cin only");
    drive16(16'hFFFF, 16'hFFFF, 1'b1, "R5 ones cin1");
    drive16(16'hFFFF, 16'hFFFF, 1'b0, "R5 ones cin0");
    drive16(16'hFFFF, 16'h0000, 1'b1, "R6 wrap");
    drive16(16'h0000, 16'hFFFF, 1'b1, "R6 wrap swapped");
    drive16(16'h0FFF, 16'h0000, 1'b1, "R3 ripple groups");
    drive16(16'h00FF, 16'h0001, 1'b0, "R3 cross boundary");
    drive16(16'h00F8, 16'h0008, 1'b0, "R7 excess wrap");
    drive16(16'h0F0F, 16'h00F1, 1'b0, "R7 wrap mid");
    drive16(16'hAAAA, 16'h5555, 1'b1, "R2 alternating");
    drive16(16'h8000, 16'h8000, 1'b0, "R1 top carry");
    drive16(16'h1234, 16'h4321, 1'b0, "R1 plain");

    for (int i = 0; i < 8192; i++) begin
      logic [12:0] v;
      logic [10:0] w;
      v = 13'(i);
      w = 11'(i % 2048);
      drive(16'($urandom), 16'($urandom), 1'($urandom),
            v[5:0], v[11:6], v[12], w[4:0], w[9:5], w[10], "R1 R2 exhaustive");
    end

    wait (sb_q.size() == 0);
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule